// File: doc/BRIEF.md
# Serial Compressed-Audio Byte Receiver

This block takes compressed audio bytes from a host over a serial link made of a dedicated select line, a shift clock and a data line. It assembles each byte with the first-sent bit as the most significant bit. Each complete byte goes into a 2048-entry byte queue. Logic further down the chip drains the queue through a valid/ready pop port. A request output tells the host when the queue still has room for a full 32-byte burst. While the request is high, the host may send 32 more bytes without checking again.

The serial inputs are sampled in the block's own clock domain. A shift-clock rising edge counts only while the select line is low. The serial pins may be shared with a control bus that has its own select. Control traffic can run while the data select is high, and it then leaves the data path untouched. If the select rises before eight bits have arrived, the bits collected so far are thrown away.

A small matcher watches every received byte for an eight-byte test-entry pattern. The pattern is 0x53, 0x70, 0xEE, a free argument byte, then four 0x00 bytes. When the pattern completes, the matcher raises a flag and reports the argument byte.

Top module: `audio_byte_rx`

## Requirements
- R1: After reset, `data_req` is 1 and `pop_valid`, `overflow` and `test_seen` are 0.
- R2: Bits are taken on rising edges of `dclk` while `dsel_n` is 0. The first bit of a byte becomes bit 7 and the eighth becomes bit 0. Bytes leave the pop port in the order they arrived.
- R3: `dclk` edges while `dsel_n` is 1 change nothing. A control transfer placed between two data bytes leaves both bytes intact, and no extra byte appears.
- R4: If `dsel_n` rises after fewer than 8 bits, those bits are dropped and no byte is queued. The next byte starts from a fresh bit count.
- R5: The queue holds exactly 2048 bytes, and all 2048 come back out unchanged and in order.
- R6: `data_req` is 1 exactly while free space (2048 minus the bytes held) is at least 32.
- R7: A byte that completes while the queue holds 2048 bytes is discarded. `overflow` then goes to 1 and stays at 1 until reset.
- R8: `pop_valid` is 1 while the queue is non-empty, and `pop_data` shows the oldest byte. A cycle with `pop_valid` and `pop_ready` both high removes one byte. If that same cycle also completes a byte, both happen and the number of bytes held does not change.
- R9: The byte run 0x53, 0x70, 0xEE, n, 0x00, 0x00, 0x00, 0x00 sets `test_seen` to 1, which stays set until reset. It also sets `test_arg` to n.
- R10: Any byte that breaks the pattern restarts matching. If that byte is 0x53, it counts as the first byte of a new match. An incomplete or broken run leaves `test_seen` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| dsel_n | input | 1 | Data select, active low |
| dclk | input | 1 | Serial shift clock, sampled by clk |
| ddin | input | 1 | Serial data in |
| data_req | output | 1 | Room for at least one 32-byte burst |
| pop_valid | output | 1 | Queue holds a byte |
| pop_ready | input | 1 | Consumer takes the head byte |
| pop_data | output | 8 | Oldest queued byte |
| overflow | output | 1 | Sticky: a byte was dropped on a full queue |
| test_seen | output | 1 | Sticky: test-entry pattern received |
| test_arg | output | 8 | Argument byte of the last test-entry pattern |

## Verification
The two functions that can fall in the same cycle are queue write (a byte completing) and queue read (a pop). The bench raises `pop_ready` for exactly the cycle after the eighth shift-clock edge is seen, which is the cycle in which the completed byte is written. It then checks that the old head left and the new byte was appended behind the remaining one. The same pairing of write and full queue is judged when a 2049th byte arrives with no pop. The bench checks that the byte was dropped and `overflow` set, by draining the queue and counting exactly 2048 bytes in the expected order.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned SEQ_LEN     = 8;
    localparam int unsigned SEQ_ARG_POS = 3;
    localparam int unsigned SEQ_PW      = $clog2(SEQ_LEN);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SEQ_PW-1:0] seq_pos_t;

    // one received byte, valid for a single cycle
    typedef struct packed {
        logic  vld;
        byte_t data;
    } beat_t;

    localparam byte_t SEQ_FIRST = 8'h53;

    // expected byte at each pattern position (argument slot is free)
    function automatic byte_t seq_expect(input seq_pos_t pos);
        case (pos)
            3'd0:    return 8'h53;
            3'd1:    return 8'h70;
            3'd2:    return 8'hEE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic seq_is_arg(input seq_pos_t pos);
        return pos == seq_pos_t'(SEQ_ARG_POS);
    endfunction

endpackage

// File: rtl/sdrx_shifter.sv
module sdrx_shifter
    import sdrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_n,
    input  logic  sclk,
    input  logic  sdin,
    output beat_t beat
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);

    logic             sclk_q;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            sh;
    logic             rise;
    byte_t            next_sh;

    always_comb begin
        rise    = sclk & ~sclk_q & ~sel_n;
        next_sh = {sh[BYTE_W-2:0], sdin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            sh      <= '0;
            beat    <= '0;
        end else begin
            sclk_q   <= sclk;
            beat.vld <= 1'b0;
            if (sel_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                sh <= next_sh;
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    bit_cnt   <= '0;
                    beat.vld  <= 1'b1;
                    beat.data <= next_sh;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R3: a byte only completes from an edge taken with select low
    a_r3_beat_needs_sel: assert property (@(posedge clk) disable iff (rst)
        beat.vld |-> $past(!sel_n));

    // R4: deselect clears any partial byte
    a_r4_drop_partial: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_n) |=> (bit_cnt == '0));

endmodule

// File: rtl/sdrx_fifo.sv
module sdrx_fifo
    import sdrx_pkg::*;
#(
    parameter int unsigned DEPTH     = 2048,
    parameter int unsigned REQ_SPACE = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t wr,
    input  logic  pop_ready,
    output logic  pop_valid,
    output byte_t pop_data,
    output logic  req,
    output logic  ovf
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wp;
    logic [AW-1:0]  rp;
    logic [CW-1:0]  cnt;
    logic           full;
    logic           push_ok;
    logic           pop_ok;

    always_comb begin
        full      = (cnt == CW'(DEPTH));
        pop_valid = (cnt != '0);
        push_ok   = wr.vld & ~full;
        pop_ok    = pop_ready & pop_valid;
        pop_data  = mem[rp];
        req       = ((CW'(DEPTH) - cnt) >= CW'(REQ_SPACE));
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (wr.vld && full) ovf <= 1'b1;
        end
    end

    // R7: overflow flag never clears outside reset
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R7: an arriving byte without a pop keeps a full queue full
    a_r7_full_hold: assert property (@(posedge clk) disable iff (rst)
        (full && wr.vld && !pop_ready) |=> full);

    // R6: request can only come back after bytes leave
    a_r6_req_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> (cnt < $past(cnt)));

    // R8: an empty queue grows by at most one byte per cycle
    a_r8_empty_step: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |=> (cnt <= CW'(1)));

endmodule

// File: rtl/sdrx_seqdet.sv
module sdrx_seqdet
    import sdrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    output logic  hit,
    output byte_t arg
);

    seq_pos_t pos;
    byte_t    arg_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            arg_cap <= '0;
            hit     <= 1'b0;
            arg     <= '0;
        end else if (beat.vld) begin
            if (seq_is_arg(pos)) begin
                arg_cap <= beat.data;
                pos     <= pos + 1'b1;
            end else if (beat.data == seq_expect(pos)) begin
                if (pos == seq_pos_t'(SEQ_LEN-1)) begin
                    hit <= 1'b1;
                    arg <= arg_cap;
                    pos <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end else begin
                pos <= (beat.data == SEQ_FIRST) ? seq_pos_t'(1) : '0;
            end
        end
    end

    // R9: the flag rises only as a byte is consumed
    a_r9_hit_on_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(hit) |-> $past(beat.vld));

    // R10: a breaking byte other than the start byte returns to idle
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        (beat.vld && !seq_is_arg(pos) && beat.data != seq_expect(pos)
         && beat.data != SEQ_FIRST) |=> (pos == '0));

endmodule

// File: rtl/audio_byte_rx.sv
module audio_byte_rx
    import sdrx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 2048,
    parameter int unsigned REQ_SPACE  = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dsel_n,
    input  logic       dclk,
    input  logic       ddin,
    output logic       data_req,
    output logic       pop_valid,
    input  logic       pop_ready,
    output logic [7:0] pop_data,
    output logic       overflow,
    output logic       test_seen,
    output logic [7:0] test_arg
);

    beat_t rx_beat;

    sdrx_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .sel_n (dsel_n),
        .sclk  (dclk),
        .sdin  (ddin),
        .beat  (rx_beat)
    );

    sdrx_fifo #(
        .DEPTH     (FIFO_DEPTH),
        .REQ_SPACE (REQ_SPACE)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr        (rx_beat),
        .pop_ready (pop_ready),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .req       (data_req),
        .ovf       (overflow)
    );

    sdrx_seqdet u_seq (
        .clk  (clk),
        .rst  (rst),
        .beat (rx_beat),
        .hit  (test_seen),
        .arg  (test_arg)
    );

    // R1: on the cycle after reset the queue is empty and requesting data
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (data_req && !pop_valid && !overflow));

endmodule

// File: tb/sim_audio_byte_rx.sv
module sim_audio_byte_rx;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int SPACE      = 32;

    // [15:12] bits sent, [8] byte expected in queue, [7:0] data
    localparam logic [15:0] VEC [8] = '{
        16'h81A5, 16'h503C, 16'h8196, 16'h8101,
        16'h30FF, 16'h8180, 16'h817E, 16'h1080
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dsel_n = 1'b1;
    logic       dclk = 1'b0;
    logic       ddin = 1'b0;
    logic       pop_ready = 1'b0;
    logic       data_req;
    logic       pop_valid;
    logic [7:0] pop_data;
    logic       overflow;
    logic       test_seen;
    logic [7:0] test_arg;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_byte_rx u0 (
        .clk       (clk),
        .rst       (rst),
        .dsel_n    (dsel_n),
        .dclk      (dclk),
        .ddin      (ddin),
        .data_req  (data_req),
        .pop_valid (pop_valid),
        .pop_ready (pop_ready),
        .pop_data  (pop_data),
        .overflow  (overflow),
        .test_seen (test_seen),
        .test_arg  (test_arg)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] d, input int n, input bit pop_last);
        @(negedge clk) dsel_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            ddin = d[7-i];
            @(negedge clk);
            @(negedge clk);
            dclk = 1'b1;
            @(negedge clk);
            if (pop_last && i == n-1) pop_ready = 1'b1;
            @(negedge clk);
            pop_ready = 1'b0;
            dclk = 1'b0;
        end
        @(negedge clk) dsel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d);
        send_bits(d, 8, 1'b0);
    endtask

    task automatic pop_one();
        @(negedge clk) pop_ready = 1'b1;
        @(negedge clk) pop_ready = 1'b0;
    endtask

    task automatic ctl_noise();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) ddin = i[0];
            dclk = 1'b1;
            @(negedge clk) dclk = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();

        // R1 reset state
        chk(data_req == 1'b1, "R1 data_req", data_req, 1);
        chk(pop_valid == 1'b0, "R1 pop_valid", pop_valid, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        chk(test_seen == 1'b0, "R1 test_seen", test_seen, 0);

        // R2 / R4 vector table
        foreach (VEC[k]) begin
            send_bits(VEC[k][7:0], int'(VEC[k][15:12]), 1'b0);
            if (VEC[k][8]) begin
                chk(pop_valid == 1'b1, "R2 byte queued", pop_valid, 1);
                chk(pop_data == VEC[k][7:0], "R2 msb-first data", pop_data, VEC[k][7:0]);
                pop_one();
                chk(pop_valid == 1'b0, "R2 single byte", pop_valid, 0);
            end else begin
                chk(pop_valid == 1'b0, "R4 partial dropped", pop_valid, 0);
            end
        end

        // R3 control traffic between two data bytes
        send_byte(8'hC3);
        ctl_noise();
        chk(pop_data == 8'hC3, "R3 head after noise", pop_data, 8'hC3);
        send_byte(8'h5A);
        chk(pop_data == 8'hC3, "R3 first byte", pop_data, 8'hC3);
        pop_one();
        chk(pop_data == 8'h5A, "R3 second byte", pop_data, 8'h5A);
        pop_one();
        chk(pop_valid == 1'b0, "R3 no extra byte", pop_valid, 0);

        // R8 push and pop in the same cycle
        send_byte(8'hA1);
        send_byte(8'hA2);
        send_bits(8'hA3, 8, 1'b1);
        chk(pop_data == 8'hA2, "R8 head after joint cycle", pop_data, 8'hA2);
        pop_one();
        chk(pop_data == 8'hA3, "R8 new byte appended", pop_data, 8'hA3);
        pop_one();
        chk(pop_valid == 1'b0, "R8 count held", pop_valid, 0);

        // R9 clean pattern
        send_byte(8'h53); send_byte(8'h70); send_byte(8'hEE); send_byte(8'h2A);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        chk(test_seen == 1'b0, "R9 not yet complete", test_seen, 0);
        send_byte(8'h00);
        chk(test_seen == 1'b1, "R9 pattern seen", test_seen, 1);
        chk(test_arg == 8'h2A, "R9 argument", test_arg, 8'h2A);

        // R10 broken pattern then restart on mismatching start byte
        do_reset();
        send_byte(8'h53); send_byte(8'h70); send_byte(8'hEE); send_byte(8'h09);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h01);
        chk(test_seen == 1'b0, "R10 broken run", test_seen, 0);
        send_byte(8'h53); send_byte(8'h53); send_byte(8'h70); send_byte(8'hEE);
        send_byte(8'h07); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h00);
        chk(test_seen == 1'b1, "R10 overlapping restart", test_seen, 1);
        chk(test_arg == 8'h07, "R10 argument", test_arg, 8'h07);

        // R5 / R6 / R7 fill, overflow, drain
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            send_byte(pat(i));
            chk(data_req == ((DEPTH - (i + 1)) >= SPACE), "R6 request while filling",
                data_req, ((DEPTH - (i + 1)) >= SPACE));
        end
        chk(overflow == 1'b0, "R7 no overflow at exact capacity", overflow, 0);
        send_byte(8'hFF);
        chk(overflow == 1'b1, "R7 overflow set", overflow, 1);
        chk(data_req == 1'b0, "R6 request low when full", data_req, 0);
        for (int j = 0; j < DEPTH; j++) begin
            chk(pop_valid == 1'b1, "R5 byte present", pop_valid, 1);
            chk(pop_data == pat(j), "R5 order kept", pop_data, pat(j));
            pop_one();
            chk(data_req == ((j + 1) >= SPACE), "R6 request while draining",
                data_req, ((j + 1) >= SPACE));
        end
        chk(pop_valid == 1'b0, "R7 extra byte dropped", pop_valid, 0);
        chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule